// File: doc/BRIEF.md
# Per-Destination Acknowledge Coalescing Tracker

This block watches one edge-triggered interrupt line whose sender needs to know whether a tick was lost. For each destination processor it keeps one bit that says whether that processor still owes an end-of-interrupt (EOI). It also keeps a count of these outstanding acknowledgements. When a new assertion arrives, the block answers in the same cycle. If the count is zero, it raises `deliver` so that the router sends the interrupt. If the count is non-zero, it raises `coalesced` instead and drops the assertion, so that software can account for the lost tick.

The router reports the outcome of each delivery on the `dlv_*` inputs. A successful delivery loads the bitmap with the destinations that were reached, and the count becomes the number of those destinations. A failed delivery clears both. EOIs from destinations clear their bits one at a time. The block also offers two repair paths:
- a single-destination restore, which forces one bit to match a supplied pending flag;
- a full resync, which rebuilds the bitmap and count from the live pending status of every destination.

The block starts the same full rebuild by itself if an update would take the count below zero. All state updates take effect at the clock edge after the input is seen.

Top module: `ack_coalesce_tracker`

## Requirements
- R1: With `req_assert` high, `deliver` is 1 and `coalesced` is 0 in the same cycle when `pend_cnt` is 0. `coalesced` is 1 and `deliver` is 0 when `pend_cnt` is greater than 0. With `req_assert` low, both are 0. An assertion never changes the stored state.
- R2: When `dlv_valid` is high and `dlv_ok` is high, `pend_map` becomes `dlv_map` on the next edge and `pend_cnt` becomes the number of ones in `dlv_map`. Bit i stands for destination i.
- R3: When `dlv_valid` is high and `dlv_ok` is low (a failed or negative delivery result), `pend_map` and `pend_cnt` both become 0.
- R4: An EOI (`eoi_valid`) from a destination whose bit is set clears that bit and lowers `pend_cnt` by one.
- R5: An EOI from a destination whose bit is clear leaves `pend_map` and `pend_cnt` unchanged.
- R6: A restore (`one_valid`) sets or clears the bit of `one_dest` to equal `one_pending`. `pend_cnt` moves by one only when the bit changes.
- R7: A `resync` loads `pend_map` from `live_pending` and sets `pend_cnt` to its number of ones. The same rebuild happens whenever an update would take the count below zero.
- R8: `trk_clear` clears `pend_map` and `pend_cnt` on the next edge. After `rst_n` is low, both are also 0.
- R9: When several updates arrive in one cycle, only one is applied, in this priority order: `trk_clear`, delivery result, `resync`, restore, EOI.
- R10: `pend_cnt` always equals the number of ones in `pend_map` and never exceeds NDEST. NDEST defaults to 8, and the full bitmap gives a count of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trk_clear | input | 1 | Clear bitmap and count |
| req_assert | input | 1 | New assertion of the tracked line |
| dlv_valid | input | 1 | Delivery result present |
| dlv_ok | input | 1 | Delivery succeeded (low means a negative result) |
| dlv_map | input | NDEST | Destinations reached by the delivery |
| eoi_valid | input | 1 | EOI received |
| eoi_dest | input | $clog2(NDEST) | Destination that sent the EOI |
| one_valid | input | 1 | Restore one destination |
| one_dest | input | $clog2(NDEST) | Destination to restore |
| one_pending | input | 1 | Whether that destination still owes an EOI |
| resync | input | 1 | Rebuild everything from `live_pending` |
| live_pending | input | NDEST | Current pending-EOI status of each destination |
| coalesced | output | 1 | Assertion dropped as coalesced |
| deliver | output | 1 | Assertion accepted and should be routed |
| pend_cnt | output | $clog2(NDEST+1) | Outstanding acknowledgement count |
| pend_map | output | NDEST | Destinations still owing an EOI |

## Verification
The checker's step properties assume that destination indices are below NDEST and that inputs are stable at the clock edge. Each step property is guarded by the absence of every higher-priority update, so it relies on the R9 order instead of assuming that updates never overlap. The stimulus changes inputs only on the falling edge and uses only the destination indices 0 to 7. It applies updates one at a time, except in the cases that deliberately collide to test priority.

// File: rtl/ack_coalesce_tracker.sv
module ack_coalesce_tracker #(
  parameter int NDEST = 8,
  localparam int DW = (NDEST > 1) ? $clog2(NDEST) : 1,
  localparam int CW = $clog2(NDEST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trk_clear,
  input  logic             req_assert,
  input  logic             dlv_valid,
  input  logic             dlv_ok,
  input  logic [NDEST-1:0] dlv_map,
  input  logic             eoi_valid,
  input  logic [DW-1:0]    eoi_dest,
  input  logic             one_valid,
  input  logic [DW-1:0]    one_dest,
  input  logic             one_pending,
  input  logic             resync,
  input  logic [NDEST-1:0] live_pending,
  output logic             coalesced,
  output logic             deliver,
  output logic [CW-1:0]    pend_cnt,
  output logic [NDEST-1:0] pend_map
);

  function automatic logic [CW-1:0] ones(input logic [NDEST-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < NDEST; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  logic [NDEST-1:0] map_q, map_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy;

  assign busy      = (cnt_q != '0);
  assign coalesced = req_assert & busy;
  assign deliver   = req_assert & ~busy;
  assign pend_cnt  = cnt_q;
  assign pend_map  = map_q;

  always_comb begin
    map_d = map_q;
    cnt_d = cnt_q;
    if (trk_clear) begin
      map_d = '0;
      cnt_d = '0;
    end else if (dlv_valid) begin
      map_d = dlv_ok ? dlv_map : '0;
      cnt_d = dlv_ok ? ones(dlv_map) : '0;
    end else if (resync) begin
      map_d = live_pending;
      cnt_d = ones(live_pending);
    end else if (one_valid) begin
      if (one_pending && !map_q[one_dest]) begin
        map_d[one_dest] = 1'b1;
        cnt_d = cnt_q + 1'b1;
      end else if (!one_pending && map_q[one_dest]) begin
        if (busy) begin
          map_d[one_dest] = 1'b0;
          cnt_d = cnt_q - 1'b1;
        end else begin
          map_d = live_pending;
          cnt_d = ones(live_pending);
        end
      end
    end else if (eoi_valid && map_q[eoi_dest]) begin
      if (busy) begin
        map_d[eoi_dest] = 1'b0;
        cnt_d = cnt_q - 1'b1;
      end else begin
        map_d = live_pending;
        cnt_d = ones(live_pending);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      cnt_q <= '0;
    end else begin
      map_q <= map_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

module ack_coalesce_tracker_chk #(
  parameter int NDEST = 8,
  localparam int DW = (NDEST > 1) ? $clog2(NDEST) : 1,
  localparam int CW = $clog2(NDEST + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trk_clear,
  input logic             req_assert,
  input logic             dlv_valid,
  input logic             dlv_ok,
  input logic [NDEST-1:0] dlv_map,
  input logic             eoi_valid,
  input logic [DW-1:0]    eoi_dest,
  input logic             one_valid,
  input logic             resync,
  input logic             coalesced,
  input logic             deliver,
  input logic [CW-1:0]    pend_cnt,
  input logic [NDEST-1:0] pend_map
);

  logic quiet_hi;
  assign quiet_hi = !trk_clear && !dlv_valid && !resync && !one_valid;

  assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({coalesced, deliver}) && (req_assert == (coalesced || deliver)));

  assert_ok_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trk_clear && dlv_valid && dlv_ok) |=> (pend_map == $past(dlv_map)));

  assert_fail_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trk_clear && dlv_valid && !dlv_ok) |=> (pend_cnt == '0 && pend_map == '0));

  assert_eoi_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_hi && eoi_valid && pend_map[eoi_dest] && pend_cnt != '0)
      |=> (pend_cnt == $past(pend_cnt) - 1'b1));

  assert_eoi_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_hi && eoi_valid && !pend_map[eoi_dest])
      |=> ($stable(pend_map) && $stable(pend_cnt)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trk_clear |=> (pend_cnt == '0 && pend_map == '0));

  assert_cnt_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == CW'($countones(pend_map))) && (pend_cnt <= CW'(NDEST)));

endmodule

bind ack_coalesce_tracker ack_coalesce_tracker_chk #(.NDEST(NDEST)) u_chk (
  .clk(clk), .rst_n(rst_n), .trk_clear(trk_clear), .req_assert(req_assert),
  .dlv_valid(dlv_valid), .dlv_ok(dlv_ok), .dlv_map(dlv_map),
  .eoi_valid(eoi_valid), .eoi_dest(eoi_dest), .one_valid(one_valid),
  .resync(resync), .coalesced(coalesced), .deliver(deliver),
  .pend_cnt(pend_cnt), .pend_map(pend_map)
);

// File: tb/ack_coalesce_tracker_test.sv
module ack_coalesce_tracker_test;
  localparam int N = 8;

  typedef struct {
    logic [3:0] cnt;
    logic [7:0] map;
    string      tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic trk_clear = 0, req_assert = 0, dlv_valid = 0, dlv_ok = 0;
  logic [7:0] dlv_map = '0, live_pending = '0;
  logic eoi_valid = 0, one_valid = 0, one_pending = 0, resync = 0;
  logic [2:0] eoi_dest = '0, one_dest = '0;
  logic coalesced, deliver;
  logic [3:0] pend_cnt;
  logic [7:0] pend_map;

  int errors = 0, checks = 0;
  bit finished = 0;
  exp_t q[$];
  logic [7:0] m_map = '0;

  always #2.5 clk = ~clk;

  ack_coalesce_tracker #(.NDEST(N)) uut (.*);

  function automatic logic [3:0] pc(input logic [7:0] v);
    logic [3:0] s = '0;
    for (int i = 0; i < 8; i++) s = s + 4'(v[i]);
    return s;
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pend_cnt !== e.cnt || pend_map !== e.map) begin
        errors++;
        $display("FAIL %s: cnt=%0d map=%b expected cnt=%0d map=%b",
                 e.tag, pend_cnt, pend_map, e.cnt, e.map);
      end
    end
  end

  task automatic push(input string tag);
    exp_t e;
    e.cnt = pc(m_map); e.map = m_map; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    trk_clear = 0; req_assert = 0; dlv_valid = 0; dlv_ok = 0; dlv_map = '0;
    eoi_valid = 0; one_valid = 0; one_pending = 0; resync = 0; live_pending = '0;
  endtask

  // applies one cycle of stimulus already placed on the inputs; model uses R9 order
  task automatic step(input string tag);
    if (trk_clear) m_map = '0;
    else if (dlv_valid) m_map = dlv_ok ? dlv_map : '0;
    else if (resync) m_map = live_pending;
    else if (one_valid) m_map[one_dest] = one_pending;
    else if (eoi_valid) m_map[eoi_dest] = 1'b0;
    @(posedge clk);
    push(tag);
    @(negedge clk);
    idle();
  endtask

  task automatic try_assert(input string tag);
    logic ec, ed;
    req_assert = 1;
    #1;
    ec = (pc(m_map) != 0);
    ed = !ec;
    checks++;
    if (coalesced !== ec || deliver !== ed) begin
      errors++;
      $display("FAIL %s: coalesced=%b deliver=%b expected %b %b", tag, coalesced, deliver, ec, ed);
    end
    step(tag);
  endtask

  task automatic deliv(input logic ok, input logic [7:0] m, input string tag);
    dlv_valid = 1; dlv_ok = ok; dlv_map = m; step(tag);
  endtask

  task automatic eoi(input logic [2:0] d, input string tag);
    eoi_valid = 1; eoi_dest = d; step(tag);
  endtask

  task automatic restore(input logic [2:0] d, input logic p, input string tag);
    one_valid = 1; one_dest = d; one_pending = p; step(tag);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (pend_cnt !== 0 || pend_map !== 0 || coalesced !== 0 || deliver !== 0) begin
      errors++;
      $display("FAIL R8 reset: cnt=%0d map=%b expected 0 0", pend_cnt, pend_map);
    end
    @(negedge clk);
    try_assert("R1 idle assert delivers");
    deliv(1, 8'b0010_1101, "R2 delivery loads 4");
    try_assert("R1 busy assert coalesces");
    eoi(3'd0, "R4 eoi set bit 0");
    eoi(3'd1, "R5 eoi clear bit 1");
    eoi(3'd1, "R5 repeated eoi no effect");
    restore(3'd1, 1, "R6 restore sets bit 1");
    restore(3'd1, 1, "R6 restore unchanged");
    restore(3'd2, 0, "R6 restore clears bit 2");
    eoi(3'd1, "R4 eoi bit 1");
    eoi(3'd3, "R4 eoi bit 3");
    eoi(3'd5, "R4 eoi bit 5 to zero");
    try_assert("R1 assert after all eoi");
    deliv(1, 8'hFF, "R10 full map count 8");
    try_assert("R1 coalesce at full");
    deliv(0, 8'hFF, "R3 failed delivery clears");
    resync = 1; live_pending = 8'b1010_0001; step("R7 resync rebuild");
    trk_clear = 1; dlv_valid = 1; dlv_ok = 1; dlv_map = 8'h0F; step("R9 clear beats delivery");
    deliv(1, 8'b0000_0110, "R2 delivery two");
    dlv_valid = 1; dlv_ok = 1; dlv_map = 8'h30; eoi_valid = 1; eoi_dest = 3'd4;
    step("R9 delivery beats eoi");
    resync = 1; live_pending = 8'h81; one_valid = 1; one_dest = 3'd2; one_pending = 1;
    step("R9 resync beats restore");
    one_valid = 1; one_dest = 3'd7; one_pending = 0; eoi_valid = 1; eoi_dest = 3'd0;
    step("R9 restore beats eoi");
    trk_clear = 1; step("R8 clear");
    try_assert("R1 assert after clear");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule